// File: doc/BRIEF.md
# Sampled Pushbutton Debouncer

This block cleans the contact bounce from a mechanical pushbutton or toggle switch. It does not time how long the input has been stable. A free-running divider counter raises a one-cycle sample strobe at evenly spaced intervals. The cleaned output is a register that loads the raw level only on strobe cycles and holds its value between them. If the interval is longer than the time the contact takes to settle, a press or release can be seen at no more than one sample point during its bounce. The output therefore moves once per real transition and never follows the chatter.

The interval is set in clock cycles by a parameter. The default is 500,000 cycles, which is about 10 ms with a 50 MHz clock. A simulation can set a few cycles instead. An optional chain of synchronizer flops can sit in front of the sampler, and a parameter sets how many flops it has. With zero stages the raw pin feeds the sampler directly. Reset returns the output to the released level, 0. Downstream edge detection is left to the user.

Top module: `btn_sample_debounce`

## Requirements
- R1: The interval counter counts 0, 1, ... up to INTERVAL_CYCLES-1 and then wraps to 0. The sample strobe is high for exactly one cycle, the cycle in which the counter holds INTERVAL_CYCLES-1. A sample is therefore taken every INTERVAL_CYCLES cycles.
- R2: The output register loads its input only at a clock edge where the strobe is high, and keeps its value at every other edge. After reset is released, the first load happens at the INTERVAL_CYCLES-th rising edge.
- R3: With SYNC_STAGES = 0, the value loaded is the raw input in the cycle just before the loading edge. With SYNC_STAGES = 2, it is the raw input from two cycles earlier than that.
- R4: The output changes at most once per interval, and only at a sample edge. Toggling of the raw input between sample points never appears at the output.
- R5: A synchronous active-high reset clears the interval counter, the synchronizer flops and the output to 0. The output reads 0 at the first edge with reset high.
- R6: After a clean, lasting change of the raw input, the output follows within INTERVAL_CYCLES + SYNC_STAGES clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every flop uses its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| btnRaw | input | 1 | Raw level from the contact, bounce included |
| btnClean | output | 1 | Debounced level; 0 is released |

## Verification
The main function is driven with bounce patterns, one input bit per cycle across each interval. The patterns differ in the bit that lies at the sample point and in the bit two cycles before it. An interval of chatter that ends high must yield 1, and one that starts high but ends low must yield 0. This shows that only the sample-point value counts and that the output holds between samples. Two patterns set the bit at the sample point against the bit two cycles earlier, and these separate the unsynchronized variant from the two-stage one. Directed cases then measure the latency after a clean edge and check that a reset mid-stream restarts the interval from zero.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;

  // Strobes issued by the interval control to the sampling datapath.
  typedef struct packed {
    logic sampleEn;   // one-cycle pulse at the end of each interval
    logic syncClr;    // clears the synchronizer and sample register
  } dbncStrobe_t;

  function automatic int unsigned cntWidth(input int unsigned limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction

endpackage

// File: rtl/dbnc_interval_ctrl.sv
module dbnc_interval_ctrl
  import dbnc_pkg::*;
#(
  parameter int unsigned INTERVAL_CYCLES = 500_000
) (
  input  logic        clk,
  input  logic        rst,
  output dbncStrobe_t strobe
);

  localparam int unsigned CNT_W = cntWidth(INTERVAL_CYCLES);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(INTERVAL_CYCLES - 1);

  logic [CNT_W-1:0] intervalCnt;
  logic             atLast;

  assign atLast = (intervalCnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      intervalCnt <= '0;
    end else if (atLast) begin
      intervalCnt <= '0;
    end else begin
      intervalCnt <= intervalCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.sampleEn = atLast && !rst;
    strobe.syncClr  = rst;
  end

  // R1: the counter never leaves its range
  a_r1_cnt_range: assert property (@(posedge clk) disable iff (rst)
    intervalCnt <= LAST_CNT);

  // R1: the counter returns to zero after the last count
  a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
    atLast |=> intervalCnt == '0);

  // R1: the counter advances by one below the last count
  a_r1_step: assert property (@(posedge clk) disable iff (rst)
    !atLast |=> intervalCnt == $past(intervalCnt) + 1'b1);

  // R5: reset clears the counter
  a_r5_cnt_clear: assert property (@(posedge clk)
    rst |=> intervalCnt == '0);

  generate
    if (INTERVAL_CYCLES > 1) begin : g_pulse
      // R1: the strobe lasts one cycle
      a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
        strobe.sampleEn |=> !strobe.sampleEn);
    end
  endgenerate

endmodule

// File: rtl/dbnc_sample_path.sv
module dbnc_sample_path
  import dbnc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  dbncStrobe_t strobe,
  input  logic        rawIn,
  output logic        cleanOut
);

  logic sampleSrc;
  logic cleanReg;

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign sampleSrc = rawIn;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] syncChain;

      always_ff @(posedge clk) begin
        if (strobe.syncClr) begin
          syncChain <= '0;
        end else begin
          syncChain[0] <= rawIn;
          for (int i = 1; i < int'(SYNC_STAGES); i++) begin
            syncChain[i] <= syncChain[i-1];
          end
        end
      end

      assign sampleSrc = syncChain[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobe.syncClr) begin
      cleanReg <= 1'b0;
    end else if (strobe.sampleEn) begin
      cleanReg <= sampleSrc;
    end
  end

  assign cleanOut = cleanReg;

  // R2: the output holds whenever no sample is taken
  a_r2_hold: assert property (@(posedge clk) disable iff (strobe.syncClr)
    !strobe.sampleEn |=> $stable(cleanOut));

  // R2: a sample edge captures the sampler input
  a_r2_load: assert property (@(posedge clk) disable iff (strobe.syncClr)
    strobe.sampleEn |=> cleanOut == $past(sampleSrc));

  // R5: reset drives the released level
  a_r5_out_clear: assert property (@(posedge clk)
    strobe.syncClr |=> !cleanOut);

endmodule

// File: rtl/btn_sample_debounce.sv
module btn_sample_debounce
  import dbnc_pkg::*;
#(
  parameter int unsigned INTERVAL_CYCLES = 500_000,
  parameter int unsigned SYNC_STAGES     = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btnRaw,
  output logic btnClean
);

  dbncStrobe_t strobe;

  dbnc_interval_ctrl #(
    .INTERVAL_CYCLES(INTERVAL_CYCLES)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe)
  );

  dbnc_sample_path #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_path (
    .clk      (clk),
    .strobe   (strobe),
    .rawIn    (btnRaw),
    .cleanOut (btnClean)
  );

  // R4: the output moves only right after a sample strobe
  a_r4_change_point: assert property (@(posedge clk) disable iff (rst)
    !$stable(btnClean) |-> $past(strobe.sampleEn));

endmodule

// File: tb/btn_sample_debounce_tb.sv
module btn_sample_debounce_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 8;
  localparam int SYNC_N     = 2;

  // Each entry: {pattern[7:0], expected without sync, expected with sync}.
  // Pattern bit b is driven in cycle b of an interval; bit N-1 is the
  // sample-point value, bit N-3 is what two sync flops deliver (R3).
  localparam logic [9:0] VECS [0:7] = '{
    {8'b00000000, 1'b0, 1'b0},
    {8'b11111111, 1'b1, 1'b1},
    {8'b01011010, 1'b0, 1'b0},
    {8'b10100101, 1'b1, 1'b1},
    {8'b00101101, 1'b0, 1'b1},
    {8'b11010110, 1'b1, 1'b0},
    {8'b11110000, 1'b1, 1'b1},
    {8'b00000000, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btnRaw = 1'b0;
  logic cleanNs;
  logic cleanSy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  btn_sample_debounce #(.INTERVAL_CYCLES(N), .SYNC_STAGES(0)) u_dut (
    .clk(clk), .rst(rst), .btnRaw(btnRaw), .btnClean(cleanNs)
  );

  btn_sample_debounce #(.INTERVAL_CYCLES(N), .SYNC_STAGES(SYNC_N)) u_dut_sync (
    .clk(clk), .rst(rst), .btnRaw(btnRaw), .btnClean(cleanSy)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    logic prevNs;
    logic prevSy;
    int   latNs;
    int   latSy;

    // R5: reset state
    repeat (3) @(negedge clk);
    check("R5 reset out (no sync)", cleanNs, 1'b0);
    check("R5 reset out (sync)", cleanSy, 1'b0);

    rst = 1'b0;
    prevNs = 1'b0;
    prevSy = 1'b0;

    // Vector walk: R2 hold, R3 sample point, R4 bounce suppression
    for (int v = 0; v < 8; v++) begin
      for (int b = 0; b < N; b++) begin
        btnRaw = VECS[v][2 + b];
        @(negedge clk);
        if (b < N - 1) begin
          check("R4 hold inside interval (no sync)", cleanNs, prevNs);
          check("R4 hold inside interval (sync)", cleanSy, prevSy);
        end
      end
      check("R3 sample value (no sync)", cleanNs, VECS[v][1]);
      check("R3 sample value (sync)", cleanSy, VECS[v][0]);
      prevNs = VECS[v][1];
      prevSy = VECS[v][0];
    end

    // R6: latency after a clean rising edge
    btnRaw = 1'b1;
    latNs = -1;
    latSy = -1;
    for (int c = 1; c <= 3 * N; c++) begin
      @(negedge clk);
      if (latNs < 0 && cleanNs) latNs = c;
      if (latSy < 0 && cleanSy) latSy = c;
    end
    check("R6 latency within bound (no sync)", (latNs > 0 && latNs <= N), 1'b1);
    check("R6 latency within bound (sync)", (latSy > 0 && latSy <= N + SYNC_N), 1'b1);

    // R5: reset mid-stream clears a high output
    rst = 1'b1;
    @(negedge clk);
    check("R5 mid-run reset (no sync)", cleanNs, 1'b0);
    check("R5 mid-run reset (sync)", cleanSy, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    // R2 / R1: first load after release lands at edge N
    for (int c = 1; c < N; c++) begin
      @(negedge clk);
      check("R2 no load before first strobe (no sync)", cleanNs, 1'b0);
      check("R2 no load before first strobe (sync)", cleanSy, 1'b0);
    end
    @(negedge clk);
    check("R1 first strobe at edge N (no sync)", cleanNs, 1'b1);
    check("R1 first strobe at edge N (sync)", cleanSy, 1'b1);

    // R4: a short low glitch between samples is ignored
    btnRaw = 1'b0;
    @(negedge clk);
    btnRaw = 1'b1;
    for (int c = 0; c < N + 2; c++) begin
      @(negedge clk);
      check("R4 glitch ignored (no sync)", cleanNs, 1'b1);
      check("R4 glitch ignored (sync)", cleanSy, 1'b1);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule